// File: doc/BRIEF.md
# System Address Range Decoder

This block maps a physical address onto the memory controller and channel that own it. A request arrives on a valid/ready handshake. The address is first checked against the memory hole and the top of memory. A table of programmable range rules is then walked in order, one rule per clock, and the first enabled rule whose range holds the address is the match. That rule's interleave field picks a 3-bit index from the address. The index selects a 4-bit target from the rule's interleave word. The target then gives a logical channel, either directly or through a modulo-3 / modulo-2 fold of the shifted address. The logical channel is looked up in a packed route word, which yields the controller and channel numbers.

A target that points at another socket is reported with a remote flag and its target id. It is not followed. Errors end the walk with a fail flag. The rule table, the interleave words and the route word are loaded through a one-word register-write port. The low and high memory bounds are static inputs.

Top module: `addr_range_decoder`

## Requirements
- R1: An accepted address at or above `topHigh`, or at or above `topLow` and below 4 GiB, returns a result with `outFail`=1 and all other result fields 0.
- R2: A config write with `cfgSel`=0 loads rule word `cfgIdx`, `cfgSel`=1 loads interleave word `cfgIdx`, and `cfgSel`=2 loads the route word. Rules are walked from index 0 upward. Each rule covers the addresses from one above the previous rule's limit (0 for rule 0) up to its own limit, and the first enabled match wins.
- R3: A rule is used only when its bit 0 is 1. A disabled rule still moves the running base past its limit, so an address inside its range matches no later rule.
- R4: A rule's limit is rule bits 26:7 placed at address bits 45:26, with address bits 25:0 all ones. The limit is inclusive.
- R5: Rule bits 2:1 select the interleave index as address bits 8:6, 10:8, 14:12 or 32:30 for codes 0, 1, 2, 3.
- R6: The target is the interleave-word nibble at bits 4*index+3 down to 4*index. When target bit 3 is 0, the result has `outRemote`=1, `outTarget`= target bits 2:0, `outFail`=0, and `outMc`=`outCh`=0.
- R7: When rule bit 27 is 0, the logical channel equals target bits 2:0.
- R8: When rule bit 27 is 1, rule bits 31:30 give a shift of 6, 8 or 12 for codes 0, 1, 2. Code 3 gives `outFail`=1 with the other fields 0, unless the target is remote.
- R9: With rule bit 27 set, let s = address >> shift. Rule bits 6:5 give a value v: code 0 gives s mod 3, code 1 gives s mod 2, code 2 gives (s mod 2)*2 + !(s mod 2), and code 3 gives (s mod 2)*2. The logical channel is v*2 + target bit 0.
- R10: For a local hit with logical channel L, `outMc` is route bits 3L+2:3L and `outCh` is route bits 2L+19:2L+18. Route bits above 31 read as 0. `outTarget` carries target bits 2:0.
- R11: When no enabled rule matches, the result has `outFail`=1 and all other fields 0.
- R12: After reset `outValid`=0 and `inReady`=1. `inReady` is 1 only while no walk or result is pending. A result stays valid and unchanged until `outReady` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Config write strobe |
| cfgSel | input | 2 | Config target: 0 rule, 1 interleave word, 2 route |
| cfgIdx | input | 5 | Rule index for config writes |
| cfgData | input | 32 | Config write data |
| topLow | input | 46 | Top of low memory (start of the hole below 4 GiB) |
| topHigh | input | 46 | Top of high memory (exclusive) |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Request accepted when high |
| inAddr | input | 46 | Physical address |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Result consumed when high |
| outFail | output | 1 | Decode failed |
| outRemote | output | 1 | Target is another socket |
| outTarget | output | 3 | Target id bits |
| outMc | output | 3 | Memory controller index |
| outCh | output | 2 | Channel index |

## Verification
The bench builds the block with its defaults: a 46-bit address and 24 rules. With these it can chain all 24 ranges across several GiB, so the walk reaches the last rule and runs past it. The 46-bit width also puts the hole at 2–4 GiB and interleave code 3 (address bits 32:30) within reach. A widened rule 0 spanning 16 GiB is swept through every combination of interleave code, fold enable, shift mode and sub-mode. Logical channel 7 is checked against an all-ones route word, where the channel field lies beyond bit 31 and must read as 0.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture address, clear base and result
    logic advance;  // base <= current limit + 1
    logic hit;      // register decode of the current rule
    logic miss;     // register a failure
  } stepCtl_t;

  typedef struct packed {
    logic       fail;
    logic       remote;
    logic [2:0] target;
    logic [2:0] mc;
    logic [1:0] ch;
  } decodeRes_t;

  localparam int CFG_RULE  = 0;
  localparam int CFG_ILV   = 1;
  localparam int CFG_ROUTE = 2;

  localparam int LIMIT_FIELD_W = 20;
  localparam int LIMIT_GRAN    = 26;

endpackage

// File: rtl/addr_dec_ctrl.sv
module addr_dec_ctrl
  import addr_dec_pkg::*;
#(
  parameter int NUM_RULES = 24,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             outOfRange,
  input  logic             hitNow,
  output stepCtl_t         ctl,
  output logic [IDX_W-1:0] scanIdx,
  output logic             inReady,
  output logic             outValid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RULES - 1);

  scanState_t state, stateNext;
  logic [IDX_W-1:0] idxNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    idxNext   = scanIdx;
    inReady   = 1'b0;
    outValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.load = 1'b1;
          idxNext  = '0;
          if (outOfRange) begin
            ctl.miss  = 1'b1;
            stateNext = ST_DONE;
          end else begin
            stateNext = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (hitNow) begin
          ctl.hit   = 1'b1;
          stateNext = ST_DONE;
        end else if (scanIdx == LAST_IDX) begin
          ctl.miss  = 1'b1;
          stateNext = ST_DONE;
        end else begin
          ctl.advance = 1'b1;
          idxNext     = scanIdx + 1'b1;
        end
      end
      ST_DONE: begin
        outValid = 1'b1;
        if (outReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      state   <= stateNext;
      scanIdx <= idxNext;
    end
  end

endmodule

// File: rtl/addr_dec_path.sv
module addr_dec_path
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W    = 46,
  parameter int NUM_RULES = 24,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic [ADDR_W-1:0] topLow,
  input  logic [ADDR_W-1:0] topHigh,
  input  logic [ADDR_W-1:0] inAddr,
  input  stepCtl_t          ctl,
  input  logic [IDX_W-1:0]  scanIdx,
  output logic              outOfRange,
  output logic              hitNow,
  output decodeRes_t        result
);

  localparam logic [ADDR_W-1:0] FOUR_GIB = ADDR_W'(64'h1_0000_0000);
  localparam int PAIRS = ADDR_W / 2;
  localparam logic [LIMIT_GRAN-1:0] LOW_ONES = '1;

  logic [31:0] ruleMem [NUM_RULES];
  logic [31:0] ilvMem  [NUM_RULES];
  logic [31:0] routeReg;
  logic [ADDR_W-1:0] addrReg, baseReg;

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        ruleMem[i] <= '0;
        ilvMem[i]  <= '0;
      end
      routeReg <= '0;
    end else if (cfgWe) begin
      if (int'(cfgSel) == CFG_ROUTE) routeReg <= cfgData;
      else if (int'(cfgIdx) < NUM_RULES) begin
        if (int'(cfgSel) == CFG_RULE) ruleMem[cfgIdx] <= cfgData;
        else if (int'(cfgSel) == CFG_ILV) ilvMem[cfgIdx] <= cfgData;
      end
    end
  end

  assign outOfRange = (inAddr >= topHigh) || ((inAddr >= topLow) && (inAddr < FOUR_GIB));

  // current rule
  logic [31:0] curRule, curIlv;
  logic [ADDR_W-1:0] limit;
  assign curRule = ruleMem[scanIdx];
  assign curIlv  = ilvMem[scanIdx];
  assign limit   = ADDR_W'({curRule[26:7], LOW_ONES});
  assign hitNow  = curRule[0] && (addrReg >= baseReg) && (addrReg <= limit);

  logic [3:0] unusedBits;
  assign unusedBits = {curRule[29:28], curRule[4:3]};

  // interleave index and target nibble
  logic [2:0] ilvIdx;
  logic [3:0] nibble;
  always_comb begin
    unique case (curRule[2:1])
      2'd0:    ilvIdx = addrReg[8:6];
      2'd1:    ilvIdx = addrReg[10:8];
      2'd2:    ilvIdx = addrReg[14:12];
      default: ilvIdx = addrReg[32:30];
    endcase
  end
  assign nibble = curIlv[{ilvIdx, 2'b00} +: 4];

  // modulo-3 by summing base-4 digits (4^k = 1 mod 3)
  function automatic logic [1:0] modThree(input logic [ADDR_W-1:0] v);
    logic [2:0] acc;
    acc = '0;
    for (int k = 0; k < PAIRS; k++) begin
      acc = acc + {1'b0, v[2*k +: 2]};
      if (acc >= 3'd3) acc = acc - 3'd3;
    end
    if (ADDR_W % 2 == 1) begin
      acc = acc + {2'b00, v[ADDR_W-1]};
      if (acc >= 3'd3) acc = acc - 3'd3;
    end
    return acc[1:0];
  endfunction

  // logical channel
  logic [3:0] shiftAmt;
  logic       modeBad;
  logic [ADDR_W-1:0] shifted;
  logic [1:0] foldVal;
  logic [2:0] lch;
  always_comb begin
    modeBad = 1'b0;
    unique case (curRule[31:30])
      2'd0:    shiftAmt = 4'd6;
      2'd1:    shiftAmt = 4'd8;
      2'd2:    shiftAmt = 4'd12;
      default: begin shiftAmt = 4'd6; modeBad = 1'b1; end
    endcase
    shifted = addrReg >> shiftAmt;
    unique case (curRule[6:5])
      2'd0:    foldVal = modThree(shifted);
      2'd1:    foldVal = {1'b0, shifted[0]};
      2'd2:    foldVal = {shifted[0], ~shifted[0]};
      default: foldVal = {shifted[0], 1'b0};
    endcase
    lch = curRule[27] ? {foldVal, nibble[0]} : nibble[2:0];
  end

  // route lookup
  logic [33:0] routeWide;
  decodeRes_t hitRes;
  assign routeWide = {2'b00, routeReg};
  always_comb begin
    hitRes        = '0;
    hitRes.remote = ~nibble[3];
    hitRes.target = nibble[2:0];
    if (nibble[3]) begin
      if (curRule[27] && modeBad) begin
        hitRes = '0;
        hitRes.fail = 1'b1;
      end else begin
        hitRes.mc = routeWide[int'(lch) * 3 +: 3];
        hitRes.ch = routeWide[int'(lch) * 2 + 18 +: 2];
      end
    end
  end

  decodeRes_t failRes;
  always_comb begin
    failRes      = '0;
    failRes.fail = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      baseReg <= '0;
      result  <= '0;
    end else begin
      if (ctl.load) begin
        addrReg <= inAddr;
        baseReg <= '0;
        result  <= '0;
      end
      if (ctl.advance) baseReg <= limit + 1'b1;
      if (ctl.hit)     result  <= hitRes;
      if (ctl.miss)    result  <= failRes;
    end
  end

endmodule

// File: rtl/addr_range_decoder.sv
module addr_range_decoder
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W    = 46,
  parameter int NUM_RULES = 24,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic [ADDR_W-1:0] topLow,
  input  logic [ADDR_W-1:0] topHigh,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic              outFail,
  output logic              outRemote,
  output logic [2:0]        outTarget,
  output logic [2:0]        outMc,
  output logic [1:0]        outCh
);

  stepCtl_t ctl;
  logic [IDX_W-1:0] scanIdx;
  logic outOfRange, hitNow;
  decodeRes_t result;

  addr_dec_ctrl #(.NUM_RULES(NUM_RULES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .outOfRange(outOfRange), .hitNow(hitNow), .ctl(ctl), .scanIdx(scanIdx),
    .inReady(inReady), .outValid(outValid)
  );

  addr_dec_path #(.ADDR_W(ADDR_W), .NUM_RULES(NUM_RULES)) u_path (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .topLow(topLow), .topHigh(topHigh), .inAddr(inAddr),
    .ctl(ctl), .scanIdx(scanIdx), .outOfRange(outOfRange), .hitNow(hitNow),
    .result(result)
  );

  assign outFail   = result.fail;
  assign outRemote = result.remote;
  assign outTarget = result.target;
  assign outMc     = result.mc;
  assign outCh     = result.ch;

endmodule

// File: rtl/addr_dec_checker.sv
module addr_dec_checker #(
  parameter int ADDR_W    = 46,
  parameter int NUM_RULES = 24,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [1:0]        cfgSel,
  input logic [IDX_W-1:0]  cfgIdx,
  input logic [31:0]       cfgData,
  input logic [ADDR_W-1:0] topLow,
  input logic [ADDR_W-1:0] topHigh,
  input logic              inValid,
  input logic              inReady,
  input logic [ADDR_W-1:0] inAddr,
  input logic              outValid,
  input logic              outReady,
  input logic              outFail,
  input logic              outRemote,
  input logic [2:0]        outTarget,
  input logic [2:0]        outMc,
  input logic [1:0]        outCh
);

  localparam logic [ADDR_W-1:0] FOUR_GIB = ADDR_W'(64'h1_0000_0000);

  logic [38:0] unusedCfg;
  assign unusedCfg = {cfgWe, cfgSel, 1'b0, cfgData, 5'(cfgIdx)};

  a_r1_hole_reject: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && ((inAddr >= topHigh) || ((inAddr >= topLow) && (inAddr < FOUR_GIB))))
    |=> (outValid && outFail));

  a_r12_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady)
    |=> (outValid && $stable({outFail, outRemote, outTarget, outMc, outCh})));

  a_r12_no_accept_pending: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid);

  a_r6_remote_not_fail: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(outFail && outRemote));

  a_r6_remote_no_route: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRemote) |-> (outMc == 3'd0 && outCh == 2'd0));

  a_r11_fail_clean: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFail) |-> (outTarget == 3'd0 && outMc == 3'd0 && outCh == 2'd0));

endmodule

bind addr_range_decoder addr_dec_checker #(.ADDR_W(ADDR_W), .NUM_RULES(NUM_RULES)) u_chk (.*);

// File: tb/tb_addr_range_decoder.sv
module tb_addr_range_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [4:0] cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic [45:0] topLow = '0, topHigh = '0;
  logic inValid = 1'b0, outReady = 1'b0;
  logic [45:0] inAddr = '0;
  logic inReady, outValid, outFail, outRemote;
  logic [2:0] outTarget, outMc;
  logic [1:0] outCh;

  int total = 0, bad = 0;
  logic [31:0] mRule [24];
  logic [31:0] mIlv [24];
  logic [31:0] mRoute = '0;
  logic [45:0] lastLimit;

  always #5 clk = ~clk;

  addr_range_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .topLow(topLow), .topHigh(topHigh), .inValid(inValid),
    .inReady(inReady), .inAddr(inAddr), .outValid(outValid), .outReady(outReady),
    .outFail(outFail), .outRemote(outRemote), .outTarget(outTarget), .outMc(outMc),
    .outCh(outCh)
  );

  // expected {fail, remote, target, mc, ch} from the requirements
  function automatic logic [9:0] model(input logic [45:0] a);
    logic [45:0] base, lim;
    logic [2:0] idx;
    logic [3:0] nib;
    logic [45:0] s;
    logic [1:0] v;
    logic [2:0] l;
    logic [33:0] rw;
    int hit, sh;
    if (a >= topHigh || (a >= topLow && a < 46'h1_0000_0000)) return 10'b10_0000_0000;
    base = '0;
    hit = -1;
    for (int i = 0; i < 24; i++) begin
      lim = {mRule[i][26:7], 26'h3FF_FFFF};
      if (hit < 0 && mRule[i][0] && a >= base && a <= lim) hit = i;
      if (hit < 0) base = lim + 46'd1;
    end
    if (hit < 0) return 10'b10_0000_0000;
    case (mRule[hit][2:1])
      2'd0: idx = a[8:6];
      2'd1: idx = a[10:8];
      2'd2: idx = a[14:12];
      default: idx = a[32:30];
    endcase
    nib = mIlv[hit][idx*4 +: 4];
    if (!nib[3]) return {2'b01, nib[2:0], 5'b0};
    if (!mRule[hit][27]) l = nib[2:0];
    else begin
      case (mRule[hit][31:30])
        2'd0: sh = 6;
        2'd1: sh = 8;
        2'd2: sh = 12;
        default: return 10'b10_0000_0000;
      endcase
      s = a >> sh;
      case (mRule[hit][6:5])
        2'd0: v = 2'(s % 3);
        2'd1: v = {1'b0, s[0]};
        2'd2: v = {s[0], ~s[0]};
        default: v = {s[0], 1'b0};
      endcase
      l = {v, nib[0]};
    end
    rw = {2'b00, mRoute};
    return {2'b00, nib[2:0], rw[int'(l)*3 +: 3], rw[int'(l)*2 + 18 +: 2]};
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgIdx = 5'(idx); cfgData = d;
    if (sel == 2'd0) mRule[idx] = d;
    else if (sel == 2'd1) mIlv[idx] = d;
    else mRoute = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runCheck(input logic [45:0] a, input string tag, input int hold);
    logic [9:0] exp, got;
    int n;
    exp = model(a);
    @(negedge clk);
    inAddr = a; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    n = 0;
    while (!outValid && n < 100) begin @(negedge clk); n++; end
    total++;
    if (!outValid) begin
      bad++;
      $display("FAIL %s no result for %h: got outValid=0 expected 1", tag, a);
      return;
    end
    got = {outFail, outRemote, outTarget, outMc, outCh};
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%b expected=%b", tag, a, got, exp);
    end
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      total++;
      if (!outValid || {outFail, outRemote, outTarget, outMc, outCh} !== exp) begin
        bad++;
        $display("FAIL R12 held result changed: got valid=%b %b expected valid=1 %b",
                 outValid, {outFail, outRemote, outTarget, outMc, outCh}, exp);
      end
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [19:0] lf;
    logic [63:0] r64;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 24; i++) begin mRule[i] = '0; mIlv[i] = '0; end
    topLow = 46'h0_8000_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      bad++;
      $display("FAIL R12 reset: got outValid=%b inReady=%b expected 0 1", outValid, inReady);
    end

    // R2: random chained table
    lf = '0;
    for (int i = 0; i < 24; i++) begin
      lf = lf + 20'(1 + $urandom % 6);
      cfgWrite(2'd0, i, {2'($urandom), 2'b00, 1'($urandom), lf, 2'($urandom), 2'b00,
                         2'($urandom), 1'(($urandom % 8) != 0)});
      cfgWrite(2'd1, i, $urandom);
    end
    cfgWrite(2'd2, 0, $urandom);
    lastLimit = {lf, 26'h3FF_FFFF};
    topHigh = lastLimit + 46'h800_0000;
    for (int k = 0; k < 300; k++) begin
      r64 = {$urandom, $urandom};
      runCheck(46'(r64 % (64'(lastLimit) + 64'h1000_0000)), "R2", (k % 7 == 0) ? 3 : 0);
    end

    // R1 hole and top bound
    runCheck(topHigh, "R1", 0);
    runCheck(topHigh + 46'd5, "R1", 0);
    runCheck(topLow, "R1", 2);
    runCheck(46'h0_FFFF_FFFF, "R1", 0);
    runCheck(topLow - 46'd1, "R1", 0);
    runCheck(46'h1_0000_0000, "R1", 0);

    // R11 beyond the last limit
    runCheck(lastLimit + 46'd1, "R11", 0);

    // R4 inclusive limit edge of rule 0
    cfgWrite(2'd0, 0, mRule[0] | 32'h1);
    runCheck({mRule[0][26:7], 26'h3FF_FFFF}, "R4", 0);
    runCheck({mRule[0][26:7], 26'h3FF_FFFF} + 46'd1, "R4", 0);

    // R3 disabled rule still advances base
    cfgWrite(2'd0, 1, mRule[1] & ~32'h1);
    runCheck({mRule[0][26:7], 26'h3FF_FFFF} + 46'd1, "R3", 0);
    runCheck({mRule[1][26:7], 26'h3FF_FFFF}, "R3", 0);
    runCheck({mRule[1][26:7], 26'h3FF_FFFF} + 46'd1, "R3", 0);

    // R5..R9 sweep over rule 0 spanning 16 GiB
    for (int sel = 0; sel < 4; sel++)
      for (int m3 = 0; m3 < 2; m3++)
        for (int md = 0; md < 4; md++)
          for (int sb = 0; sb < 4; sb++) begin
            cfgWrite(2'd0, 0, {2'(md), 2'b00, 1'(m3), 20'h00100, 2'(sb), 2'b00, 2'(sel), 1'b1});
            cfgWrite(2'd1, 0, $urandom | 32'h8888_0000);
            for (int k = 0; k < 2; k++) begin
              r64 = {$urandom, $urandom};
              r64 = 64'h1_0000_0000 + (r64 % 64'h3_0000_0000);
              if (model(46'(r64))[8]) runCheck(46'(r64), "R6", 0);
              else if (m3 == 0) runCheck(46'(r64), (k == 0) ? "R5" : "R7", 0);
              else if (md == 3) runCheck(46'(r64), "R8", 0);
              else runCheck(46'(r64), "R9", 0);
            end
          end

    // R6 remote directed: all targets remote with id 5
    cfgWrite(2'd0, 0, {2'd0, 2'b00, 1'b0, 20'h00100, 2'd0, 2'b00, 2'd3, 1'b1});
    cfgWrite(2'd1, 0, 32'h5555_5555);
    runCheck(46'h2_4000_0000, "R6", 0);

    // R10 logical channel 7 against an all-ones route
    cfgWrite(2'd1, 0, 32'hFFFF_FFFF);
    cfgWrite(2'd2, 0, 32'hFFFF_FFFF);
    runCheck(46'h1_2345_6780, "R10", 0);
    cfgWrite(2'd2, 0, 32'h3A5C_96E1);
    cfgWrite(2'd1, 0, 32'hEDCB_A98F);
    for (int k = 0; k < 8; k++) runCheck(46'h1_0000_0000 + 46'(k * 64), "R10", 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule